// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a clocked model of a small synchronous static RAM with a 32-bit word split into four byte lanes. Every control, address and write-data input is captured on the rising clock edge. An access is opened by one of two active-low address strobes. The processor-side strobe counts only while the first enable is low, and it always reads. The controller-side strobe reads or writes depending on the write controls, and it deselects the part when the three enables do not all agree. Once an access is open, cycles without a strobe continue it as a burst. In each such cycle the advance input either steps a two-bit counter that supplies the two lowest address bits, or holds the address as a wait cycle. Each continuation cycle reads or writes according to the write controls.

The burst order comes from a static order input, either counting up modulo four or XOR-ing the loaded low bits with the step count. Writes cover all four lanes under a global write. Otherwise a byte-write enable qualifies individual lane lines. Read data comes out of an output register one clock after its address is captured, on a separate output bus. A companion enable flag is gated directly by an asynchronous output enable. A sleep input freezes the block into standby and memory contents are kept.

Top module: `sbsram_top`

## Requirements
- R1: The part is selected only when sel0_n=0, sel1=1 and sel2_n=0. A strobe that is taken while not selected writes nothing, ends any open burst, and leaves dout_en low from the following cycles on until a new access.
- R2: A processor strobe (strobe_p_n=0) is taken only while sel0_n=0. When selected it loads addr_i and reads, even if gw_n or the byte controls request a write. With sel0_n=1 it is ignored.
- R3: A controller strobe (strobe_c_n=0, with no processor strobe taken) loads addr_i and writes din at that same edge when the write controls request a write, and reads otherwise. Burst continuation cycles also write or read according to the write controls.
- R4: Data for a read whose address is captured at edge k is in dout from edge k+1, with dout_en high for exactly that one cycle when oe_n=0. A write cycle produces no dout_en.
- R5: With order_i=0 the burst low address bits run base, base+1, base+2, base+3 modulo 4, one step per cycle with adv_n=0.
- R6: With order_i=1 the burst low address bits are the loaded base XOR the step count 0, 1, 2, 3.
- R7: A continuation cycle with adv_n=1 accesses the same address as the previous cycle.
- R8: gw_n=0 writes all four lanes, whatever bwen_n and bw_n hold.
- R9: With gw_n=1, lane i (din bits 8i+7..8i, lane 0 the first byte) is written only when bwen_n=0 and bw_n[i]=0. With bwen_n=1 the cycle is a read and the word is unchanged.
- R10: dout_en is 0 whenever oe_n=1 and follows oe_n at once, without a clock edge.
- R11: At an edge with sleep=1, strobes, writes and burst steps are ignored, an open burst is closed, and any read result due is dropped so dout_en is 0. Memory contents survive.
- R12: After reset, dout_en is 0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr_i | input | ADDR_W | Word address |
| sel0_n | input | 1 | First enable, active low, also gates the processor strobe |
| sel1 | input | 1 | Second enable, active high |
| sel2_n | input | 1 | Third enable, active low |
| strobe_p_n | input | 1 | Processor address strobe, active low, read only |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high is a wait cycle |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| gw_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write lines, active low |
| din | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby request, active high |
| dout | output | LANES*LANE_W | Output data register |
| dout_en | output | 1 | Output drivers enabled |

## Verification
Reads are tried as single accesses, as four-beat bursts in linear order and in interleaved order, and as a burst with a wait cycle. The start address has low bits 01 because, with base 10, the two orders give the same sequence. Writes are tried as a global write with conflicting byte controls, a two-lane byte write over a known word, a byte enable left off with all lane lines low (which must read rather than write), and an interleaved write burst read back in order. Each enable is dropped one at a time under a write strobe, to catch a partial select decode, and the sleep and output-enable cases separate a clocked gate from an asynchronous one.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  // Low two address bits for a burst beat.
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] step,
                                           input logic       interleave);
    if (interleave) return base ^ step;
    return base + step;
  endfunction

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              strobe_p_n,
  input  logic              strobe_c_n,
  input  logic              adv_n,
  input  logic              order_i,
  input  logic              gw_n,
  input  logic              bwen_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              sleep,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [LANES-1:0]  lane_we,
  output logic              rd_issue,
  output logic              cont_evt,
  output logic              rd_q,
  output logic [ADDR_W-1:0] rd_addr_q
);

  localparam int HI_W = ADDR_W - 2;

  function automatic logic [LANES-1:0] lane_mask(input logic g_n,
                                                 input logic e_n,
                                                 input logic [LANES-1:0] b_n);
    if (!g_n) return '1;
    if (!e_n) return ~b_n;
    return '0;
  endfunction

  logic             selected, p_take, c_take, start_evt, desel_evt, step_evt, wr_req;
  logic [LANES-1:0] req_mask;
  logic [HI_W-1:0]  hi_q;
  logic [1:0]       base_q, cnt_q, cnt_use;
  logic             active_q;
  acc_e             kind;

  always_comb begin
    selected  = !sel0_n && sel1 && !sel2_n;
    p_take    = !strobe_p_n && !sel0_n;
    c_take    = !p_take && !strobe_c_n;
    start_evt = (p_take || c_take) && selected && !sleep;
    desel_evt = (p_take || c_take) && !selected && !sleep;
    cont_evt  = !p_take && !c_take && active_q && !sleep;
    step_evt  = cont_evt && !adv_n;
    req_mask  = lane_mask(gw_n, bwen_n, bw_n);
    wr_req    = |req_mask;
    kind      = ACC_NONE;
    if (start_evt)     kind = (p_take || !wr_req) ? ACC_READ : ACC_WRITE;
    else if (cont_evt) kind = wr_req ? ACC_WRITE : ACC_READ;
    cnt_use   = step_evt ? cnt_q + 2'd1 : cnt_q;
    eff_addr  = start_evt ? addr_i : {hi_q, burst_low(base_q, cnt_use, order_i)};
    lane_we   = (kind == ACC_WRITE) ? req_mask : '0;
    rd_issue  = (kind == ACC_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      hi_q      <= '0;
      base_q    <= '0;
      cnt_q     <= '0;
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      if (sleep || desel_evt) begin
        active_q <= 1'b0;
      end else if (start_evt) begin
        active_q <= 1'b1;
        hi_q     <= addr_i[ADDR_W-1:2];
        base_q   <= addr_i[1:0];
        cnt_q    <= 2'd0;
      end else if (step_evt) begin
        cnt_q    <= cnt_use;
      end
      rd_q      <= rd_issue;
      rd_addr_q <= eff_addr;
    end
  end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    rd_q,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    out_valid
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[wr_addr] <= din[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (rd_q) q <= mem[rd_addr];
    end

    assign dout[g*LANE_W +: LANE_W] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= rd_q && !sleep;
  end

endmodule

// File: rtl/sbsram_top.sv
module sbsram_top #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    sel0_n,
  input  logic                    sel1,
  input  logic                    sel2_n,
  input  logic                    strobe_p_n,
  input  logic                    strobe_c_n,
  input  logic                    adv_n,
  input  logic                    order_i,
  input  logic                    gw_n,
  input  logic                    bwen_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  // Named internal events, also watched by the checker.
  logic [ADDR_W-1:0] eff_addr;
  logic [LANES-1:0]  lane_we;
  logic              rd_issue;
  logic              cont_evt;
  logic              rd_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              out_valid;

  sbsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
    .adv_n(adv_n), .order_i(order_i),
    .gw_n(gw_n), .bwen_n(bwen_n), .bw_n(bw_n), .sleep(sleep),
    .eff_addr(eff_addr), .lane_we(lane_we), .rd_issue(rd_issue),
    .cont_evt(cont_evt), .rd_q(rd_q), .rd_addr_q(rd_addr_q)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .wr_addr(eff_addr),
    .din(din), .rd_q(rd_q), .rd_addr(rd_addr_q), .sleep(sleep),
    .dout(dout), .out_valid(out_valid)
  );

  assign dout_en = out_valid && !oe_n;

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel0_n,
  input logic              sel1,
  input logic              sel2_n,
  input logic              strobe_p_n,
  input logic              strobe_c_n,
  input logic              adv_n,
  input logic              gw_n,
  input logic              sleep,
  input logic              oe_n,
  input logic              dout_en,
  input logic              rd_issue,
  input logic              cont_evt,
  input logic [LANES-1:0]  lane_we,
  input logic [ADDR_W-1:0] eff_addr
);

  logic sel_ok;
  assign sel_ok = (sel0_n == 1'b0) && (sel1 == 1'b1) && (sel2_n == 1'b0);

  always_comb begin
    assert_oe_gate_R10: assert (!(oe_n && dout_en));
  end

  assert_read_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue ##1 !sleep) |=> (oe_n || dout_en));

  assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !dout_en);

  assert_ps_readonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_p_n && !sel0_n) |-> (lane_we == '0));

  assert_global_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gw_n && strobe_p_n && !strobe_c_n && sel_ok && !sleep) |-> (&lane_we));

  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_evt && adv_n) |-> (eff_addr == $past(eff_addr)));

  assert_desel_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_c_n && strobe_p_n && !sel_ok) |-> (lane_we == '0));

endmodule

bind sbsram_top sbsram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
  .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n), .adv_n(adv_n),
  .gw_n(gw_n), .sleep(sleep), .oe_n(oe_n), .dout_en(dout_en),
  .rd_issue(rd_issue), .cont_evt(cont_evt), .lane_we(lane_we),
  .eff_addr(eff_addr)
);

// File: tb/sbsram_top_test.sv
module sbsram_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr_i;
  logic        sel0_n, sel1, sel2_n, strobe_p_n, strobe_c_n, adv_n, order_i;
  logic        gw_n, bwen_n, oe_n, sleep;
  logic [3:0]  bw_n;
  logic [31:0] din, dout;
  logic        dout_en;

  sbsram_top uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .sel0_n(sel0_n), .sel1(sel1),
    .sel2_n(sel2_n), .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
    .adv_n(adv_n), .order_i(order_i), .gw_n(gw_n), .bwen_n(bwen_n),
    .bw_n(bw_n), .din(din), .oe_n(oe_n), .sleep(sleep), .dout(dout),
    .dout_en(dout_en)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] mdl [256];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  b_a;
  int          b_i;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] a, input string req);
    exp_q.push_back(mdl[a]);
    tag_q.push_back(req);
  endtask

  function automatic logic [7:0] baddr();
    logic [1:0] lo;
    logic [1:0] ib;
    ib = 2'(b_i);
    if (order_i) lo = {b_a[1] ^ ib[1], b_a[0] ^ ib[0]};
    else         lo = 2'((int'(b_a[1:0]) + b_i) % 4);
    return {b_a[7:2], lo};
  endfunction

  task automatic set_idle();
    strobe_p_n = 1; strobe_c_n = 1; adv_n = 1; gw_n = 1; bwen_n = 1;
    bw_n = 4'hF; sel0_n = 0; sel1 = 1; sel2_n = 0; sleep = 0; din = '0;
  endtask

  task automatic apply_write(input logic [7:0] a, input logic [31:0] d,
                             input logic g, input logic e, input logic [3:0] b);
    for (int i = 0; i < 4; i++)
      if (!g || (!e && !b[i])) mdl[a][i*8 +: 8] = d[i*8 +: 8];
  endtask

  task automatic c_access(input logic [7:0] a, input logic [31:0] d,
                          input logic g, input logic e, input logic [3:0] b,
                          input string req);
    @(negedge clk); set_idle();
    strobe_c_n = 0; addr_i = a; din = d; gw_n = g; bwen_n = e; bw_n = b;
    b_a = a; b_i = 0;
    if (g && (e || b == 4'hF)) push(a, req);
    else apply_write(a, d, g, e, b);
  endtask

  task automatic c_read(input logic [7:0] a, input string req);
    c_access(a, 32'h0, 1'b1, 1'b1, 4'hF, req);
  endtask

  task automatic p_read(input logic [7:0] a, input string req);
    @(negedge clk); set_idle();
    strobe_p_n = 0; gw_n = 0; addr_i = a; b_a = a; b_i = 0;
    push(a, req);
  endtask

  task automatic step_rd(input bit adv, input string req);
    @(negedge clk); set_idle();
    adv_n = !adv;
    if (adv) b_i++;
    push(baddr(), req);
  endtask

  task automatic step_wr(input logic [31:0] d);
    @(negedge clk); set_idle();
    adv_n = 0; gw_n = 0; din = d; b_i++;
    apply_write(baddr(), d, 1'b0, 1'b1, 4'hF);
  endtask

  task automatic desel();
    @(negedge clk); set_idle();
    strobe_c_n = 0; sel1 = 0;
  endtask

  // Monitor: pops one expected word per enabled output cycle.
  initial begin
    forever begin
      @(posedge clk); #3;
      if (rst_n && dout_en) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected output", dout, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(dout === e, t, dout, e);
        end
      end
    end
  end

  initial begin
    #(20000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; oe_n = 0; order_i = 0; addr_i = '0; set_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dout_en == 1'b0, "R12 reset output off", {31'b0, dout_en}, 32'h0);
    rst_n = 1;

    // Fill a few words with global writes (R3, R8).
    c_access(8'h10, 32'hA0A1A2A3, 1'b0, 1'b1, 4'hF, "R3");
    c_access(8'h11, 32'hB0B1B2B3, 1'b0, 1'b1, 4'hF, "R3");
    c_access(8'h12, 32'hC0C1C2C3, 1'b0, 1'b1, 4'hF, "R3");
    c_access(8'h13, 32'hD0D1D2D3, 1'b0, 1'b0, 4'hF, "R8 gw over byte lines");
    c_read(8'h10, "R3 single read");
    c_read(8'h13, "R8 global write result");
    desel();

    // Read latency (R4).
    repeat (2) @(negedge clk);
    c_read(8'h12, "R4 latency data");
    desel();
    chk(dout_en == 1'b0, "R4 not yet valid", {31'b0, dout_en}, 32'h0);
    @(negedge clk);
    chk(dout_en == 1'b1, "R4 valid after one clock", {31'b0, dout_en}, 32'h1);

    // Linear burst from base 01 (R5), processor strobe reads despite gw (R2).
    order_i = 0;
    p_read(8'h11, "R2 ps reads with gw low");
    step_rd(1, "R5 linear beat1");
    step_rd(1, "R5 linear beat2");
    step_rd(1, "R5 linear beat3");
    desel();

    // Interleaved burst from base 01 (R6).
    @(negedge clk); order_i = 1;
    p_read(8'h11, "R6");
    step_rd(1, "R6 interleaved beat1");
    step_rd(1, "R6 interleaved beat2");
    step_rd(1, "R6 interleaved beat3");
    desel();

    // Wait cycle (R7).
    @(negedge clk); order_i = 0;
    p_read(8'h11, "R7");
    step_rd(0, "R7 wait holds address");
    step_rd(1, "R7 advance after wait");
    desel();

    // Byte writes (R9).
    c_access(8'h20, 32'h11223344, 1'b0, 1'b1, 4'hF, "R9");
    c_access(8'h20, 32'hAABBCCDD, 1'b1, 1'b0, 4'b1010, "R9");
    c_access(8'h20, 32'h55555555, 1'b1, 1'b1, 4'b0000, "R9 bwen high is a read");
    c_read(8'h20, "R9 lanes 0 and 2 written");
    desel();

    // Interleaved write burst, then read back (R3, R6).
    @(negedge clk); order_i = 1;
    c_access(8'h31, 32'h31313131, 1'b0, 1'b1, 4'hF, "R3");
    step_wr(32'h30303030);
    step_wr(32'h33333333);
    step_wr(32'h32323232);
    desel();
    c_read(8'h30, "R3 burst write beat1");
    c_read(8'h33, "R3 burst write beat2");
    c_read(8'h32, "R3 burst write beat3");
    desel();
    @(negedge clk); order_i = 0;

    // Enable decode (R1).
    c_access(8'h40, 32'h40404040, 1'b0, 1'b1, 4'hF, "R1");
    @(negedge clk); set_idle(); strobe_c_n = 0; gw_n = 0; addr_i = 8'h40;
    sel0_n = 1; din = 32'hBAD00001;
    @(negedge clk); set_idle(); strobe_c_n = 0; gw_n = 0; addr_i = 8'h40;
    sel2_n = 1; din = 32'hBAD00002;
    @(negedge clk); set_idle(); strobe_c_n = 0; gw_n = 0; addr_i = 8'h40;
    sel1 = 0; din = 32'hBAD00003;
    @(negedge clk); set_idle(); strobe_p_n = 0; sel0_n = 1; addr_i = 8'h40;
    @(negedge clk); set_idle(); adv_n = 0;
    @(negedge clk);
    chk(dout_en == 1'b0, "R2 ps ignored with sel0_n high", {31'b0, dout_en}, 32'h0);
    c_read(8'h40, "R1 deselected writes dropped");
    desel();

    // Deselect ends a burst (R1).
    p_read(8'h11, "R1");
    desel();
    @(negedge clk); set_idle(); adv_n = 0;
    @(negedge clk);
    chk(dout_en == 1'b0, "R1 burst ended", {31'b0, dout_en}, 32'h0);
    @(negedge clk);
    chk(dout_en == 1'b0, "R1 burst stays ended", {31'b0, dout_en}, 32'h0);

    // Asynchronous output enable (R10).
    desel();
    @(negedge clk); set_idle(); oe_n = 1; strobe_c_n = 0; addr_i = 8'h10;
    @(negedge clk); set_idle(); strobe_c_n = 0; sel1 = 0;
    @(negedge clk);
    chk(dout_en == 1'b0, "R10 oe high blocks", {31'b0, dout_en}, 32'h0);
    #1 oe_n = 0;
    #1 chk(dout_en == 1'b1 && dout == mdl[8'h10], "R10 oe low at once", dout, mdl[8'h10]);

    // Standby (R11).
    desel();
    @(negedge clk); set_idle(); sleep = 1; strobe_c_n = 0; gw_n = 0;
    addr_i = 8'h10; din = 32'hDEADBEEF;
    @(negedge clk); set_idle(); sleep = 1; strobe_p_n = 0; addr_i = 8'h10;
    @(negedge clk); set_idle();
    @(negedge clk);
    chk(dout_en == 1'b0, "R11 strobes ignored in sleep", {31'b0, dout_en}, 32'h0);
    c_read(8'h10, "R11 memory kept");
    desel();
    @(negedge clk); set_idle(); strobe_p_n = 0; addr_i = 8'h30;
    @(negedge clk); set_idle(); sleep = 1; adv_n = 0;
    @(negedge clk); set_idle(); adv_n = 0;
    chk(dout_en == 1'b0, "R11 pending read dropped", {31'b0, dout_en}, 32'h0);
    @(negedge clk);
    chk(dout_en == 1'b0, "R11 burst closed", {31'b0, dout_en}, 32'h0);

    desel();
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all reads delivered", 32'(exp_q.size()), 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule